// File: doc/BRIEF.md
# Divide-by-nine three-phase datapath

This block takes one input word per three-cycle frame and produces three results from it, each on its own fixed cycle. A narrow bit field of the word is passed straight through one clock after capture. A wider field is divided by nine: the truncated quotient is delivered two clocks after capture and the remainder three clocks after capture. The division is built as plain combinational logic with no pipeline stages. Its inputs come from a capture register that stays constant for the whole frame, so the quotient path may be constrained as a two-cycle path and the remainder path as a three-cycle path.

A frame starts when the word-valid strobe is seen while the block is idle, or on the last cycle of the current frame. Words can therefore arrive back to back every three clocks. A strobe that arrives during the first two cycles of a running frame is dropped and reported on a one-cycle error flag. Each result has its own one-cycle valid pulse, and each result register holds its value until its next load.

Top module: `nine_div_frame`

## Requirements
- R1: While `rst` is high at a clock edge, all output data, all valid flags and `proto_err` are 0 after that edge.
- R2: A `word_vld` strobe sampled when no frame is running, or on the third cycle of a frame, starts a new frame and captures `word_in`.
- R3: One clock edge after the capture edge, `fld_out` takes `word_in[3:0]` of the captured word and `fld_vld` is high for exactly that one cycle.
- R4: Two clock edges after the capture edge, `quo_out` takes the truncated quotient `word_in[15:4] / 9` and `quo_vld` is high for exactly that one cycle.
- R5: Three clock edges after the capture edge, `rem_out` takes `word_in[15:4] mod 9`, which is always below 9, and `rem_vld` is high for exactly that one cycle.
- R6: Each result register keeps its value in every cycle in which it is not loaded.
- R7: A strobe sampled on the first or second cycle of a running frame changes no result and no frame timing, and `proto_err` is high for one cycle after that edge.
- R8: Strobes spaced exactly three cycles apart are all accepted, and at most one of the three valid flags is high in any cycle.
- R9: Quotient and remainder are exact at the edges of the range: dividends 0, 8, 9, 17, 18 and 4095 give 0/0, 0/8, 1/0, 1/8, 2/0 and 455/0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| word_vld | input | 1 | Input word strobe |
| word_in | input | 16 | Input word |
| fld_out | output | 4 | Pass-through field of the captured word |
| fld_vld | output | 1 | One-cycle pulse when `fld_out` is loaded |
| quo_out | output | 12 | Quotient of the upper field by nine |
| quo_vld | output | 1 | One-cycle pulse when `quo_out` is loaded |
| rem_out | output | 4 | Remainder of the upper field by nine |
| rem_vld | output | 1 | One-cycle pulse when `rem_out` is loaded |
| proto_err | output | 1 | One-cycle pulse after a strobe that came too early |

## Verification
Relative to the edge that captures a word, the field result is due one edge later, the quotient two edges later and the remainder three edges later. A rejected strobe shows on the error flag one edge after it is sampled. The bench drives inputs at the falling edge, advances a behavioural model at each rising edge, and compares every output and flag at the next falling edge. Each result is therefore checked in the exact cycle it should appear, and in every other cycle it must still hold its old value. The stimulus covers single words, back-to-back words at the three-cycle spacing, strobes that arrive too early, a strobe held high on every cycle, the edges of the dividend range, and random words with random gaps.

// File: rtl/ndf_pkg.sv
package ndf_pkg;

    localparam int DIVISOR = 9;
    localparam int REM_W   = $clog2(DIVISOR);

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_FLD  = 2'd1,
        PH_QUO  = 2'd2,
        PH_REM  = 2'd3
    } frame_ph_t;

    typedef struct packed {
        logic             qb;
        logic [REM_W-1:0] rm;
    } div_step_t;

    function automatic div_step_t div_step(input logic [REM_W:0] part);
        div_step_t s;
        if (part >= (REM_W+1)'(DIVISOR)) begin
            s.qb = 1'b1;
            s.rm = REM_W'(part - (REM_W+1)'(DIVISOR));
        end else begin
            s.qb = 1'b0;
            s.rm = part[REM_W-1:0];
        end
        return s;
    endfunction

endpackage

// File: rtl/ndf_seq.sv
module ndf_seq
    import ndf_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic in_valid,
    output logic take,
    output logic reject,
    output logic ld_fld,
    output logic ld_quo,
    output logic ld_rem
);

    frame_ph_t ph;

    always_comb begin
        take   = in_valid && (ph == PH_IDLE || ph == PH_REM);
        reject = in_valid && !take;
        ld_fld = (ph == PH_FLD);
        ld_quo = (ph == PH_QUO);
        ld_rem = (ph == PH_REM);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph <= PH_IDLE;
        end else if (take) begin
            ph <= PH_FLD;
        end else begin
            unique case (ph)
                PH_FLD:  ph <= PH_QUO;
                PH_QUO:  ph <= PH_REM;
                default: ph <= PH_IDLE;
            endcase
        end
    end

    // R2
    frame_start_chk: assert property (@(posedge clk) disable iff (rst)
        take |=> (ph == PH_FLD));

    // R7
    early_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && ph == PH_FLD) |=> (ph == PH_QUO));

endmodule

// File: rtl/ndf_div9.sv
module ndf_div9
    import ndf_pkg::*;
#(
    parameter int DIV_W = 12
) (
    input  logic [DIV_W-1:0] dvd,
    output logic [DIV_W-1:0] quo,
    output logic [REM_W-1:0] rem
);

    logic [REM_W-1:0] chain [0:DIV_W];

    assign chain[0] = '0;

    for (genvar i = 0; i < DIV_W; i++) begin : g_stage
        div_step_t st;
        assign st                = div_step({chain[i], dvd[DIV_W-1-i]});
        assign quo[DIV_W-1-i]    = st.qb;
        assign chain[i+1]        = st.rm;
    end

    assign rem = chain[DIV_W];

endmodule

// File: rtl/ndf_hold_reg.sv
module ndf_hold_reg #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         ld,
    input  logic [W-1:0] d,
    output logic [W-1:0] q,
    output logic         vld
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q   <= '0;
            vld <= 1'b0;
        end else begin
            vld <= ld;
            if (ld) q <= d;
        end
    end

    // R6
    hold_value_chk: assert property (@(posedge clk) disable iff (rst)
        !ld |=> $stable(q));

endmodule

// File: rtl/nine_div_frame.sv
module nine_div_frame
    import ndf_pkg::*;
#(
    parameter int WORD_W  = 16,
    parameter int FLD_LSB = 0,
    parameter int FLD_W   = 4,
    parameter int DIV_LSB = 4,
    parameter int DIV_W   = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              word_vld,
    input  logic [WORD_W-1:0] word_in,
    output logic [FLD_W-1:0]  fld_out,
    output logic              fld_vld,
    output logic [DIV_W-1:0]  quo_out,
    output logic              quo_vld,
    output logic [REM_W-1:0]  rem_out,
    output logic              rem_vld,
    output logic              proto_err
);

    logic              take, reject, ld_fld, ld_quo, ld_rem;
    logic [WORD_W-1:0] cap_word;
    logic [DIV_W-1:0]  div_q;
    logic [REM_W-1:0]  div_r;

    ndf_seq u_seq (
        .clk      (clk),
        .rst      (rst),
        .in_valid (word_vld),
        .take     (take),
        .reject   (reject),
        .ld_fld   (ld_fld),
        .ld_quo   (ld_quo),
        .ld_rem   (ld_rem)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cap_word  <= '0;
            proto_err <= 1'b0;
        end else begin
            proto_err <= reject;
            if (take) cap_word <= word_in;
        end
    end

    // Slow path: cap_word -> quotient register is a two-cycle path,
    // cap_word -> remainder register is a three-cycle path.
    ndf_div9 #(.DIV_W(DIV_W)) u_div (
        .dvd (cap_word[DIV_LSB +: DIV_W]),
        .quo (div_q),
        .rem (div_r)
    );

    ndf_hold_reg #(.W(FLD_W)) u_fld (
        .clk (clk), .rst (rst), .ld (ld_fld),
        .d   (cap_word[FLD_LSB +: FLD_W]),
        .q   (fld_out), .vld (fld_vld)
    );

    ndf_hold_reg #(.W(DIV_W)) u_quo (
        .clk (clk), .rst (rst), .ld (ld_quo),
        .d   (div_q),
        .q   (quo_out), .vld (quo_vld)
    );

    ndf_hold_reg #(.W(REM_W)) u_rem (
        .clk (clk), .rst (rst), .ld (ld_rem),
        .d   (div_r),
        .q   (rem_out), .vld (rem_vld)
    );

    // R7
    cap_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (ld_fld || ld_quo) |=> $stable(cap_word));

    // R7
    err_cause_chk: assert property (@(posedge clk) disable iff (rst)
        proto_err |-> $past(word_vld));

    // R4
    quo_follows_fld_chk: assert property (@(posedge clk) disable iff (rst)
        fld_vld |=> quo_vld);

    // R5
    rem_follows_quo_chk: assert property (@(posedge clk) disable iff (rst)
        quo_vld |=> rem_vld);

    // R8
    single_valid_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({fld_vld, quo_vld, rem_vld}));

    // R5
    rem_range_chk: assert property (@(posedge clk) disable iff (rst)
        rem_vld |-> (rem_out < REM_W'(DIVISOR)));

endmodule

// File: tb/nine_div_frame_bench.sv
module nine_div_frame_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        word_vld = 1'b0;
    logic [15:0] word_in = '0;
    logic [3:0]  fld_out;
    logic        fld_vld;
    logic [11:0] quo_out;
    logic        quo_vld;
    logic [3:0]  rem_out;
    logic        rem_vld;
    logic        proto_err;

    always #2 clk = ~clk;

    nine_div_frame u_nine_div_frame (
        .clk (clk), .rst (rst), .word_vld (word_vld), .word_in (word_in),
        .fld_out (fld_out), .fld_vld (fld_vld),
        .quo_out (quo_out), .quo_vld (quo_vld),
        .rem_out (rem_out), .rem_vld (rem_vld),
        .proto_err (proto_err)
    );

    int total = 0;
    int bad   = 0;
    int cycles = 0;
    bit done  = 0;

    // behavioural reference state
    int age = 0;
    int held = 0;
    int e_f = 0, e_fv = 0, e_q = 0, e_qv = 0, e_r = 0, e_rv = 0, e_err = 0;
    string scen = "R1 reset";

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s [%s] act=%0d exp=%0d", tag, scen, act, exp);
        end
    endtask

    task automatic model_edge();
        int dv;
        e_fv = 0; e_qv = 0; e_rv = 0; e_err = 0;
        if (rst) begin
            age = 0; held = 0; e_f = 0; e_q = 0; e_r = 0;
            return;
        end
        dv = (held >> 4) & 'hFFF;
        if (age == 1) begin e_f = held & 'hF; e_fv = 1; end
        if (age == 2) begin e_q = dv / 9; e_qv = 1; end
        if (age == 3) begin e_r = dv % 9; e_rv = 1; end
        if (word_vld && (age == 0 || age == 3)) begin
            held = int'(word_in);
            age  = 1;
        end else begin
            if (word_vld) e_err = 1;
            age = (age == 0 || age == 3) ? 0 : age + 1;
        end
    endtask

    task automatic compare_all();
        chk("R3 fld_out",   int'(fld_out),   e_f);
        chk("R3 fld_vld",   int'(fld_vld),   e_fv);
        chk("R4 quo_out",   int'(quo_out),   e_q);
        chk("R4 quo_vld",   int'(quo_vld),   e_qv);
        chk("R5 rem_out",   int'(rem_out),   e_r);
        chk("R5 rem_vld",   int'(rem_vld),   e_rv);
        chk("R7 proto_err", int'(proto_err), e_err);
    endtask

    task automatic tick();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare_all();
    endtask

    task automatic drive(input bit v, input logic [15:0] w);
        word_vld = v;
        word_in  = w;
        tick();
        word_vld = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) drive(1'b0, 16'h0);
    endtask

    task automatic one_word(input int dvd, input int fld);
        drive(1'b1, 16'((dvd << 4) | fld));
        idle(3);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            done = 1;
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        // R1: reset state
        word_vld = 1'b1;
        word_in  = 16'hFFFF;
        tick();
        tick();
        word_vld = 1'b0;
        chk("R1 all zero", int'({fld_out, fld_vld, quo_out, quo_vld,
                                 rem_out, rem_vld, proto_err}), 0);
        rst = 1'b0;

        scen = "R2 single word";
        one_word(12'h123, 4'hA);
        scen = "R6 hold";
        idle(5);

        scen = "R9 range edges";
        one_word(0, 1);
        one_word(8, 2);
        one_word(9, 3);
        one_word(17, 4);
        one_word(18, 5);
        one_word(4095, 15);
        chk("R9 455 quotient", int'(quo_out), 455);
        chk("R9 zero remainder", int'(rem_out), 0);

        scen = "R8 three-cycle cadence";
        for (int k = 0; k < 6; k++) begin
            drive(1'b1, 16'(16'h1357 * (k + 3)));
            idle(2);
        end
        idle(3);

        scen = "R7 early strobes";
        drive(1'b1, 16'h4C21);
        drive(1'b1, 16'hFFFF);
        drive(1'b1, 16'h0000);
        idle(4);
        chk("R7 result untouched", int'(quo_out), 16'h4C2 / 9);

        scen = "R8 strobe every cycle";
        for (int k = 0; k < 10; k++) drive(1'b1, 16'(16'h0F0F + 16'd97 * k));
        idle(4);

        scen = "R2 random mix";
        for (int k = 0; k < 80; k++) begin
            drive(1'b1, 16'($urandom));
            idle(int'($urandom % 5));
        end
        idle(4);

        scen = "R1 reset mid-frame";
        drive(1'b1, 16'hABCD);
        rst = 1'b1;
        tick();
        rst = 1'b0;
        chk("R1 cleared", int'({fld_out, quo_out, rem_out}), 0);
        idle(4);

        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule